// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Idle Parking

This block decides which of several bus masters owns one slave port of a multi-master crossbar. Every cycle it presents a one-hot grant vector and the index of the connected master. Ownership changes only at access boundaries, which the connected master marks with a last-beat pulse, or while the slave is idle. The address decoding, the data multiplexing and the configuration registers sit outside this block. They supply the request lines, the last-beat pulse and a static configuration word.

Two selection rules are available. The first is round-robin: a rotating pointer starts the search one past the most recent winner and wraps around the master count. The second is fixed priority: each master carries its own programmable priority value, the largest value wins, and a tie goes to the higher master index.

When no master is requesting, a parking policy decides what happens to the connection. The slave can be released, left with the master that used it last, or handed to a configured default master. The grant is registered. A master that is already parked on the slave therefore starts its access with no wait, and every other master waits one cycle for arbitration.

Top module: `slave_arbiter`

## Requirements
- R1: After reset no master is connected (grant all zero, conn_valid low) and the round-robin pointer is 0, so the first round-robin decision favours master 0.
- R2: grant is zero or one-hot; when conn_valid is high exactly bit conn_idx of grant is set, and when it is low grant is zero.
- R3: While the connected master keeps its request high and last_beat is low, the connection and conn_idx stay unchanged in the next cycle.
- R4: With cfg_arb_type = 0 (round-robin), the winner at a decision point is the first requesting master at or after the pointer, searching upward and wrapping modulo the master count; the pointer then moves to the winner plus one, modulo the count.
- R5: With cfg_park_mode = 0 or 3 (release), a decision point with no request pending disconnects the slave in the next cycle.
- R6: With cfg_park_mode = 1 (keep last), a decision point with no request pending leaves the connection and conn_idx as they were.
- R7: With cfg_park_mode = 2 (fixed default), a decision point with no request pending connects master cfg_default_idx in the next cycle, or releases the slave if that index is not below the master count.
- R8: A master that is already connected sees its grant in the same cycle it raises its request; any other master is granted at the earliest in the cycle after its request is first seen.
- R9: With cfg_arb_type = 1 (fixed priority), the requesting master with the numerically largest priority value wins a decision point.
- R10: In fixed-priority mode, requesters that share the largest value are resolved in favour of the highest master index.
- R11: Master i's priority is the unsigned field cfg_prio[i*PRIO_W +: PRIO_W]; each master's value is independent.

A decision point is any cycle in which the slave is not held by R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MASTERS | Request line per master |
| last_beat | input | 1 | Final beat of the connected master's current access |
| cfg_arb_type | input | 1 | 0 round-robin, 1 fixed priority |
| cfg_park_mode | input | 2 | 0 release, 1 keep last, 2 fixed default, 3 release |
| cfg_default_idx | input | IDX_W | Master that the fixed-default policy parks on |
| cfg_prio | input | N_MASTERS*PRIO_W | Packed per-master priority values |
| grant | output | N_MASTERS | One-hot grant, registered |
| conn_valid | output | 1 | A master is connected |
| conn_idx | output | IDX_W | Index of the connected master, meaningful when conn_valid is high |

## Verification
The bench builds the arbiter with five masters and a three-bit priority field. Because five is not a power of two, the round-robin wrap goes through a real modulo step rather than a free bit overflow. The three-bit index also leaves codes 5 to 7, which are not valid masters, so the fixed-default policy can be given an index with no master behind it. The priority tables are chosen so that several masters share the largest value, which places the tie-break on index in the path of ordinary traffic.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        ARB_ROUND_ROBIN = 1'b0,
        ARB_FIXED_PRIO  = 1'b1
    } arb_type_e;

    typedef enum logic [1:0] {
        PARK_RELEASE   = 2'd0,
        PARK_KEEP_LAST = 2'd1,
        PARK_DEFAULT   = 2'd2,
        PARK_RESERVED  = 2'd3
    } park_mode_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Round-robin search: first requester at or above ptr, wrapping modulo N.
module arb_rr_pick #(
    parameter  int N_MASTERS = 4,
    localparam int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [IDX_W-1:0]     ptr,
    output logic                 found,
    output logic [IDX_W-1:0]     win_idx,
    output logic [IDX_W-1:0]     ptr_next
);
    localparam int SUM_W = IDX_W + 1;
    localparam logic [SUM_W-1:0] N_LIM = SUM_W'(N_MASTERS);

    logic [SUM_W-1:0] pos;
    logic [SUM_W-1:0] inc;

    always_comb begin
        found   = |req;
        win_idx = '0;
        pos     = '0;
        // Descending scan so the smallest offset from ptr is written last.
        for (int k = N_MASTERS - 1; k >= 0; k--) begin
            pos = {1'b0, ptr} + SUM_W'(k);
            if (pos >= N_LIM) begin
                pos = pos - N_LIM;
            end
            if (req[pos[IDX_W-1:0]]) begin
                win_idx = pos[IDX_W-1:0];
            end
        end
        inc = {1'b0, win_idx} + SUM_W'(1);
        if (inc >= N_LIM) begin
            ptr_next = '0;
        end else begin
            ptr_next = inc[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/arb_prio_pick.sv
// Fixed-priority search: largest value wins, equal values go to the higher index.
module arb_prio_pick #(
    parameter  int N_MASTERS = 4,
    parameter  int PRIO_W    = 4,
    localparam int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0]        req,
    input  logic [N_MASTERS*PRIO_W-1:0] prio_flat,
    output logic                        found,
    output logic [IDX_W-1:0]            win_idx
);
    logic [PRIO_W-1:0] best;
    logic [PRIO_W-1:0] cur;

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        best    = '0;
        cur     = '0;
        // Ascending scan with >= lets a later (higher) index take a tie.
        for (int i = 0; i < N_MASTERS; i++) begin
            cur = prio_flat[i*PRIO_W +: PRIO_W];
            if (req[i] && (!found || cur >= best)) begin
                found   = 1'b1;
                best    = cur;
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter
    import arb_pkg::*;
#(
    parameter  int N_MASTERS = 4,
    parameter  int PRIO_W    = 4,
    localparam int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_MASTERS-1:0]        req,
    input  logic                        last_beat,
    input  logic                        cfg_arb_type,
    input  logic [1:0]                  cfg_park_mode,
    input  logic [IDX_W-1:0]            cfg_default_idx,
    input  logic [N_MASTERS*PRIO_W-1:0] cfg_prio,
    output logic [N_MASTERS-1:0]        grant,
    output logic                        conn_valid,
    output logic [IDX_W-1:0]            conn_idx
);
    localparam logic [IDX_W:0] N_LIM = (IDX_W + 1)'(N_MASTERS);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d;
    arb_state_t st_q;

    logic             rr_found;
    logic [IDX_W-1:0] rr_idx;
    logic [IDX_W-1:0] rr_ptr_next;
    logic             pr_found;
    logic [IDX_W-1:0] pr_idx;
    logic             hold;
    logic             default_ok;
    arb_type_e        arb_type;
    park_mode_e       park_mode;

    arb_rr_pick #(.N_MASTERS(N_MASTERS)) u_rr_pick (
        .req      (req),
        .ptr      (st_q.ptr),
        .found    (rr_found),
        .win_idx  (rr_idx),
        .ptr_next (rr_ptr_next)
    );

    arb_prio_pick #(.N_MASTERS(N_MASTERS), .PRIO_W(PRIO_W)) u_prio_pick (
        .req       (req),
        .prio_flat (cfg_prio),
        .found     (pr_found),
        .win_idx   (pr_idx)
    );

    always_comb begin
        arb_type   = arb_type_e'(cfg_arb_type);
        park_mode  = park_mode_e'(cfg_park_mode);
        default_ok = ({1'b0, cfg_default_idx} < N_LIM);
        // An access in flight keeps the slave until its final beat.
        hold       = st_q.valid && req[st_q.idx] && !last_beat;
        st_d       = st_q;

        if (!hold) begin
            if (arb_type == ARB_FIXED_PRIO && pr_found) begin
                st_d.valid = 1'b1;
                st_d.idx   = pr_idx;
            end else if (arb_type == ARB_ROUND_ROBIN && rr_found) begin
                st_d.valid = 1'b1;
                st_d.idx   = rr_idx;
                st_d.ptr   = rr_ptr_next;
            end else begin
                unique case (park_mode)
                    PARK_KEEP_LAST: begin
                        st_d.valid = st_q.valid;
                    end
                    PARK_DEFAULT: begin
                        st_d.valid = default_ok;
                        if (default_ok) begin
                            st_d.idx = cfg_default_idx;
                        end
                    end
                    default: begin
                        st_d.valid = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
        assign grant[g] = st_q.valid && (st_q.idx == IDX_W'(g));
    end

    assign conn_valid = st_q.valid;
    assign conn_idx   = st_q.idx;

endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter  int N_MASTERS = 4,
    parameter  int PRIO_W    = 4,
    localparam int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] req,
    input logic                 last_beat,
    input logic [1:0]           cfg_park_mode,
    input logic [IDX_W-1:0]     cfg_default_idx,
    input logic [N_MASTERS-1:0] grant,
    input logic                 conn_valid,
    input logic [IDX_W-1:0]     conn_idx
);
    localparam logic [IDX_W:0] N_LIM = (IDX_W + 1)'(N_MASTERS);

    logic [N_MASTERS-1:0] req_p;
    logic [1:0]           park_p;
    logic [IDX_W-1:0]     def_p;
    logic                 valid_p;
    logic [IDX_W-1:0]     idx_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_p   <= '0;
            park_p  <= '0;
            def_p   <= '0;
            valid_p <= 1'b0;
            idx_p   <= '0;
        end else begin
            req_p   <= req;
            park_p  <= cfg_park_mode;
            def_p   <= cfg_default_idx;
            valid_p <= conn_valid;
            idx_p   <= conn_idx;
        end
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (conn_valid == (grant != '0)));

    // R2
    grant_matches_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conn_valid |-> ({1'b0, conn_idx} < N_LIM) && grant[conn_idx]);

    // R3
    hold_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_valid && req[conn_idx] && !last_beat) |=> (conn_valid && $stable(conn_idx)));

    // R5
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && (cfg_park_mode == 2'd0 || cfg_park_mode == 2'd3)) |=> !conn_valid);

    // R6
    keep_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && cfg_park_mode == 2'd1) |=> ($stable(conn_valid) && $stable(conn_idx)));

    // R7
    default_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && cfg_park_mode == 2'd2)
        |=> (conn_valid == ({1'b0, def_p} < N_LIM)) && (!conn_valid || conn_idx == def_p));

    // R8
    new_owner_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_valid && (!valid_p || conn_idx != idx_p))
        |-> (req_p[conn_idx] || (park_p == 2'd2 && conn_idx == def_p)));

endmodule

bind slave_arbiter arb_chk #(.N_MASTERS(N_MASTERS), .PRIO_W(PRIO_W)) u_arb_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req             (req),
    .last_beat       (last_beat),
    .cfg_park_mode   (cfg_park_mode),
    .cfg_default_idx (cfg_default_idx),
    .grant           (grant),
    .conn_valid      (conn_valid),
    .conn_idx        (conn_idx)
);

// File: tb/slave_arbiter_tb.sv
module slave_arbiter_tb;
    localparam int  N          = 5;
    localparam int  PW         = 3;
    localparam int  IW         = 3;
    localparam time CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req;
    logic          last_beat;
    logic          cfg_arb_type;
    logic [1:0]    cfg_park_mode;
    logic [IW-1:0] cfg_default_idx;
    logic [N*PW-1:0] cfg_prio;
    logic [N-1:0]  grant;
    logic          conn_valid;
    logic [IW-1:0] conn_idx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slave_arbiter #(.N_MASTERS(N), .PRIO_W(PW)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req             (req),
        .last_beat       (last_beat),
        .cfg_arb_type    (cfg_arb_type),
        .cfg_park_mode   (cfg_park_mode),
        .cfg_default_idx (cfg_default_idx),
        .cfg_prio        (cfg_prio),
        .grant           (grant),
        .conn_valid      (conn_valid),
        .conn_idx        (conn_idx)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    // Reference model state
    int    m_valid, m_idx, m_ptr;
    string m_tag;
    int    prio_tab[N];
    int    t_type, t_park, t_def;
    logic [31:0] lf = 32'h2468_ace1;

    function automatic logic [31:0] rnd();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
        return lf;
    endfunction

    task automatic check(input string tag, input bit ok, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int exp_g;
        exp_g = m_valid ? (1 << m_idx) : 0;
        check(m_tag, conn_valid == 1'(m_valid), "conn_valid", int'(conn_valid), m_valid);
        if (m_valid != 0) check(m_tag, int'(conn_idx) == m_idx, "conn_idx", int'(conn_idx), m_idx);
        // R2: grant one-hot at conn_idx
        check("R2", int'(grant) == exp_g && $onehot0(grant), "grant", int'(grant), exp_g);
    endtask

    task automatic model(input logic [N-1:0] r, input bit lb);
        int best, bidx, ties, w;
        if (m_valid != 0 && r[m_idx] && !lb) begin
            m_tag = "R3";
        end else if (r != 0) begin
            m_valid = 1;
            if (t_type == 0) begin
                w = -1;
                for (int k = 0; k < N; k++) begin
                    if (w < 0 && r[(m_ptr + k) % N]) w = (m_ptr + k) % N;
                end
                m_idx = w;
                m_ptr = (w + 1) % N;
                m_tag = "R4";
            end else begin
                // R11: each master's value taken from its own table entry
                best = -1; bidx = 0; ties = 0;
                for (int i = 0; i < N; i++) begin
                    if (r[i]) begin
                        if (prio_tab[i] > best) begin best = prio_tab[i]; bidx = i; ties = 0; end
                        else if (prio_tab[i] == best) begin bidx = i; ties++; end
                    end
                end
                m_idx = bidx;
                m_tag = (ties > 0) ? "R10" : "R9";
            end
        end else begin
            if (t_park == 1) begin
                m_tag = "R6";
            end else if (t_park == 2) begin
                m_tag = "R7";
                if (t_def < N) begin m_valid = 1; m_idx = t_def; end
                else m_valid = 0;
            end else begin
                m_tag = "R5";
                m_valid = 0;
            end
        end
    endtask

    task automatic step(input logic [N-1:0] r, input bit lb);
        compare();
        model(r, lb);
        req       = r;
        last_beat = lb;
        @(negedge clk);
    endtask

    task automatic set_cfg(input int ty, input int pk, input int df);
        t_type = ty; t_park = pk; t_def = df;
        cfg_arb_type    = 1'(ty);
        cfg_park_mode   = 2'(pk);
        cfg_default_idx = IW'(df);
        for (int i = 0; i < N; i++) cfg_prio[i*PW +: PW] = PW'(prio_tab[i]);
    endtask

    task automatic random_run(input int cycles);
        logic [31:0] a, b;
        logic [N-1:0] r;
        for (int c = 0; c < cycles; c++) begin
            a = rnd();
            b = rnd();
            r = a[N-1:0] & b[N+7:8];
            if (b[20:19] == 2'b00) r = '0;
            step(r, (a[27:26] == 2'b00) || (b[31:30] == 2'b11));
        end
    endtask

    initial begin
        rst_n = 1'b0; req = '0; last_beat = 1'b0;
        m_valid = 0; m_idx = 0; m_ptr = 0; m_tag = "R1";
        prio_tab = '{2, 6, 6, 1, 0};
        set_cfg(0, 0, 0);
        repeat (3) @(negedge clk);
        check("R1", !conn_valid && grant == '0, "grant in reset", int'(grant), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: pointer starts at 0, so with all requesting master 0 wins
        step('1, 1'b1);
        check("R1", conn_valid && conn_idx == 0, "first rr winner", int'(conn_idx), 0);

        // R8: zero latency for the parked default, one cycle for others
        set_cfg(0, 2, 2);
        step('0, 1'b0);
        step('0, 1'b0);
        check("R8", grant[2] == 1'b1, "parked master grant at request", int'(grant), 4);
        step(5'b00100, 1'b0);
        step(5'b00100, 1'b1);
        step('0, 1'b0);
        check("R8", grant[0] == 1'b0, "other master before arbitration", int'(grant), 4);
        step(5'b00001, 1'b0);
        check("R8", grant[0] == 1'b1, "other master one cycle later", int'(grant), 1);

        // R7: default index with no master behind it releases the slave
        set_cfg(0, 2, 6);
        step('0, 1'b0);
        step('0, 1'b0);

        for (int ty = 0; ty < 2; ty++) begin
            for (int pk = 0; pk < 4; pk++) begin
                set_cfg(ty, pk, (pk + 3) % N);
                random_run(150);
            end
        end
        // R10: all equal values, highest index always wins
        prio_tab = '{4, 4, 4, 4, 4};
        set_cfg(1, 1, 0);
        random_run(120);
        // R9 and R11: distinct per-master values
        prio_tab = '{7, 0, 3, 5, 1};
        set_cfg(1, 0, 0);
        random_run(120);
        step('0, 1'b0);
        compare();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule